// File: doc/BRIEF.md
# Pixel FIFO Front End with Refill and Interrupt Control

This block is the register-side front end of an addressable-LED pixel serializer. Software writes 32-bit pixel words to a data address. Each word goes into a 32-entry FIFO, and the serializer drains that FIFO through a valid/pop handshake. The block also holds the control fields that the serializer uses: a run-enable bit, a 13-bit pixel count and a 3-bit colour-order selector.

While a transfer is running, the block raises a refill request whenever the FIFO occupancy is at or below a programmable 5-bit threshold. With the reset threshold of 16, a 16-word refill burst always fits into the remaining space. A single-cycle done pulse from the serializer ends the transfer and flags completion. Both events are kept in a write-one-to-clear status register and drive one interrupt line. That line is gated by per-source enables and by a global enable. Writes to a full FIFO are dropped and recorded in a sticky flag.

Top module: `ledpix_front`

## Requirements
- R1: Each write to address 4 pushes `bus_wdata` into the FIFO. The serializer receives the words in write order: `px_data` shows the oldest word while `px_valid` is high, and each clock edge with `px_pop` high removes one word. `level_o` gives the occupancy, from 0 to 32.
- R2: A data write while `level_o` is 32 is discarded and leaves the FIFO unchanged. It sets status bit 2, which stays set until software clears it.
- R3: The threshold is at address 1, bits 4:0, and resets to 16. On each clock edge where a transfer is active and `level_o` is at or below the threshold, status bit 1 (refill) is set.
- R4: A `ser_done` pulse sets status bit 0 (finished) on the next edge and ends the active transfer. After that, refill is no longer set until the transfer is started again.
- R5: Status is at address 3. Writing a 1 to a bit clears that bit, and writing 0 leaves it unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R6: The interrupt enables are at address 2: bit 5 is the global enable, bit 1 enables refill and bit 0 enables finished. `irq` is high exactly when the global enable is set and at least one enabled status bit (bit 1 or bit 0) is set.
- R7: Control is at address 0: bit 0 is the enable, bits 28:16 the pixel count and bits 8:6 the colour mode, each shown on its `cfg_` output. Writing it with bit 0 set starts a transfer. Writing it with bit 0 clear ends the transfer and empties the FIFO.
- R8: After reset, the FIFO is empty, the status bits are 0, `irq` is low, the enables are 0 and the control fields are 0.
- R9: A pop while the FIFO is empty is ignored: `level_o` stays 0 and `px_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| px_valid | output | 1 | FIFO holds at least one word |
| px_data | output | 32 | Oldest FIFO word |
| px_pop | input | 1 | Serializer takes the current word |
| ser_done | input | 1 | Serializer finished-transfer pulse |
| cfg_en | output | 1 | Run enable |
| cfg_len | output | 13 | Pixel count |
| cfg_mode | output | 3 | Colour-order selector |
| irq | output | 1 | Gated interrupt |
| stat_o | output | 3 | Status: bit 2 overflow, bit 1 refill, bit 0 finished |
| level_o | output | 6 | FIFO occupancy |

## Verification
The collision of interest is between setting the refill status and clearing it by software. The bench lets occupancy settle at the threshold during an active transfer, then writes a 1 to status bit 1. After that write edge it expects the bit still to read 1. As controls, the same clear must succeed when occupancy is above the threshold, and also after the done pulse has ended the transfer. A second overlap, a data write into a full FIFO, is judged by the pixel stream that the scoreboard sees: the dropped word must never come out.

// File: rtl/ledpix_pkg.sv
package ledpix_pkg;

    localparam int DATA_W     = 32;
    localparam int FIFO_DEPTH = 32;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int TRIG_W     = 5;
    localparam int LEN_W      = 13;
    localparam int MODE_W     = 3;
    localparam int ADDR_W     = 3;
    localparam int STAT_W     = 3;
    localparam int IEN_W      = 6;

    // control word field positions (software-visible layout)
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_MODE_LO = 6;
    localparam int CTL_LEN_LO  = 16;

    // status / enable bit positions
    localparam int ST_FIN  = 0;
    localparam int ST_REF  = 1;
    localparam int ST_OVF  = 2;
    localparam int IE_GLOB = 5;

    localparam logic [TRIG_W-1:0] TRIG_RESET = TRIG_W'(FIFO_DEPTH / 2);

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_TRIG = 3'd1,
        RA_IEN  = 3'd2,
        RA_STAT = 3'd3,
        RA_DATA = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [MODE_W-1:0] mode;
        logic              en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en   = w[CTL_EN_BIT];
        c.mode = w[CTL_MODE_LO +: MODE_W];
        c.len  = w[CTL_LEN_LO +: LEN_W];
        return c;
    endfunction

endpackage

// File: rtl/ledpix_fifo.sv
module ledpix_fifo #(
    parameter int W     = ledpix_pkg::DATA_W,
    parameter int DEPTH = ledpix_pkg::FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= AW'((32'(wp) + 1) % DEPTH);
            if (do_pop)  rp <= AW'((32'(rp) + 1) % DEPTH);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

endmodule

// File: rtl/ledpix_regs.sv
module ledpix_regs
    import ledpix_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  reg_addr_e                addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [LVL_W-1:0]         level,
    input  logic                     drop,
    input  logic                     done,
    output ctrl_t                    ctrl,
    output logic [TRIG_W-1:0]        trig,
    output logic [IEN_W-1:0]         ien,
    output logic [STAT_W-1:0]        stat,
    output logic                     active,
    output logic                     flush,
    output logic                     irq
);
    logic              wr_ctrl, wr_trig, wr_ien, wr_stat;
    logic [STAT_W-1:0] st_set, st_clr;

    assign wr_ctrl = we && (addr == RA_CTRL);
    assign wr_trig = we && (addr == RA_TRIG);
    assign wr_ien  = we && (addr == RA_IEN);
    assign wr_stat = we && (addr == RA_STAT);
    assign flush   = wr_ctrl && !wdata[CTL_EN_BIT];

    always_comb begin
        st_set         = '0;
        st_set[ST_FIN] = done;
        st_set[ST_REF] = active && (level <= LVL_W'(trig));
        st_set[ST_OVF] = drop;
        st_clr         = wr_stat ? wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            trig   <= TRIG_RESET;
            ien    <= '0;
            stat   <= '0;
            active <= 1'b0;
        end else begin
            if (wr_ctrl)      ctrl <= unpack_ctrl(wdata);
            if (wr_trig)      trig <= wdata[TRIG_W-1:0];
            if (wr_ien)       ien  <= wdata[IEN_W-1:0];
            if (wr_ctrl)      active <= wdata[CTL_EN_BIT];
            else if (done)    active <= 1'b0;
            stat <= st_set | (stat & ~st_clr);
        end
    end

    assign irq = ien[IE_GLOB] &&
                 ((stat[ST_REF] && ien[ST_REF]) || (stat[ST_FIN] && ien[ST_FIN]));

endmodule

// File: rtl/ledpix_front.sv
module ledpix_front
    import ledpix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 px_valid,
    output logic [DATA_W-1:0]    px_data,
    input  logic                 px_pop,
    input  logic                 ser_done,
    output logic                 cfg_en,
    output logic [LEN_W-1:0]     cfg_len,
    output logic [MODE_W-1:0]    cfg_mode,
    output logic                 irq,
    output logic [STAT_W-1:0]    stat_o,
    output logic [LVL_W-1:0]     level_o
);
    reg_addr_e         addr_e;
    ctrl_t             ctrl_q;
    logic [TRIG_W-1:0] trig_q;
    logic [IEN_W-1:0]  ien_q;
    logic              xfer_active, flush, drop, empty, push;

    assign addr_e = reg_addr_e'(bus_addr);
    assign push   = bus_we && (addr_e == RA_DATA);

    ledpix_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .din   (bus_wdata),
        .pop   (px_pop),
        .dout  (px_data),
        .level (level_o),
        .empty (empty),
        .drop  (drop)
    );

    ledpix_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (addr_e),
        .wdata  (bus_wdata),
        .level  (level_o),
        .drop   (drop),
        .done   (ser_done),
        .ctrl   (ctrl_q),
        .trig   (trig_q),
        .ien    (ien_q),
        .stat   (stat_o),
        .active (xfer_active),
        .flush  (flush),
        .irq    (irq)
    );

    assign px_valid = !empty;
    assign cfg_en   = ctrl_q.en;
    assign cfg_len  = ctrl_q.len;
    assign cfg_mode = ctrl_q.mode;

endmodule

// File: rtl/ledpix_chk.sv
module ledpix_chk
    import ledpix_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 we,
    input logic [ADDR_W-1:0]    addr,
    input logic                 pop,
    input logic                 valid,
    input logic                 done,
    input logic                 irq,
    input logic [STAT_W-1:0]    stat,
    input logic [LVL_W-1:0]     level,
    input logic [TRIG_W-1:0]    trig,
    input logic                 gie,
    input logic                 act
);
    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(FIFO_DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 3'd4 && level == LVL_W'(FIFO_DEPTH) && !pop)
        |=> (level == LVL_W'(FIFO_DEPTH) && stat[ST_OVF]));

    // R3
    refill_set_chk: assert property (@(posedge clk) disable iff (rst)
        (act && level <= LVL_W'(trig)) |=> stat[ST_REF]);

    // R4
    finish_set_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (stat[ST_FIN] && !act));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq);

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level == '0 && stat == '0 && !irq));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && pop && !(we && addr == 3'd4)) |=> (level == '0 && !valid));

endmodule

bind ledpix_front ledpix_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .addr  (bus_addr),
    .pop   (px_pop),
    .valid (px_valid),
    .done  (ser_done),
    .irq   (irq),
    .stat  (stat_o),
    .level (level_o),
    .trig  (trig_q),
    .gie   (ien_q[5]),
    .act   (xfer_active)
);

// File: tb/sim_ledpix_front.sv
module sim_ledpix_front;
    import ledpix_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              px_valid, px_pop = 1'b0, ser_done = 1'b0;
    logic [31:0]       px_data;
    logic              cfg_en, irq;
    logic [12:0]       cfg_len;
    logic [2:0]        cfg_mode, stat_o;
    logic [5:0]        level_o;

    int          n_chk = 0;
    int          n_err = 0;
    int          exp_lvl = 0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    ledpix_front u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .px_valid(px_valid), .px_data(px_data),
        .px_pop(px_pop), .ser_done(ser_done), .cfg_en(cfg_en),
        .cfg_len(cfg_len), .cfg_mode(cfg_mode), .irq(irq),
        .stat_o(stat_o), .level_o(level_o)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // driver: a word is expected only if the FIFO has room
    task automatic push_px(input logic [31:0] d);
        if (exp_lvl < 32) begin
            exp_q.push_back(d);
            exp_lvl++;
        end
        wr(3'd4, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_n(input int n);
        @(negedge clk);
        px_pop = 1'b1;
        repeat (n) @(negedge clk);
        px_pop = 1'b0;
    endtask

    task automatic flush_model();
        exp_q.delete();
        exp_lvl = 0;
    endtask

    // monitor: compares each word the serializer takes (R1)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && px_pop && px_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R1", "unexpected word", px_data, 0);
                end else begin
                    chk("R1", "pixel order", px_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    exp_lvl--;
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R8 reset state
        chk("R8", "level", level_o, 0);
        chk("R8", "status", stat_o, 0);
        chk("R8", "irq", irq, 0);
        chk("R8", "valid", px_valid, 0);
        chk("R8", "enable", cfg_en, 0);

        // R7 control fields, start transfer
        wr(3'd2, 32'h23);
        wr(3'd0, (32'd5 << 16) | (32'd2 << 6) | 32'd1);
        chk("R7", "cfg_en", cfg_en, 1);
        chk("R7", "cfg_len", cfg_len, 5);
        chk("R7", "cfg_mode", cfg_mode, 2);
        idle(1);
        // R3 refill set at empty level, R6 irq with all enables
        chk("R3", "refill when empty", stat_o, 3'b010);
        chk("R6", "irq enabled refill", irq, 1);

        // R1 fill 20 words
        for (int i = 0; i < 20; i++) push_px(32'hA000_0000 + i);
        chk("R1", "level after 20", level_o, 20);
        // R5 clear succeeds above threshold
        wr(3'd3, 32'h2);
        chk("R5", "clear above trigger", stat_o[1], 0);
        pop_n(4);
        chk("R1", "level after pops", level_o, 16);
        idle(1);
        chk("R3", "refill at trigger", stat_o[1], 1);
        // R5 set wins over clear in the same cycle
        wr(3'd3, 32'h2);
        chk("R5", "set beats clear", stat_o[1], 1);

        // R6 gating
        wr(3'd2, 32'h03);
        chk("R6", "no global enable", irq, 0);
        wr(3'd2, 32'h21);
        chk("R6", "refill not enabled", irq, 0);
        // R4 done pulse
        @(negedge clk); ser_done = 1'b1;
        @(negedge clk); ser_done = 1'b0;
        chk("R4", "finish status", stat_o[0], 1);
        chk("R6", "irq on finish", irq, 1);
        wr(3'd3, 32'h2);
        chk("R4", "no refill after done", stat_o[1], 0);

        // R2 fill to full, then one extra write
        for (int i = 0; i < 16; i++) push_px(32'hB000_0000 + i);
        chk("R2", "full level", level_o, 32);
        push_px(32'hDEAD_BEEF);
        chk("R2", "level after drop", level_o, 32);
        chk("R2", "overflow flag", stat_o[2], 1);
        pop_n(34);
        chk("R1", "all words drained", exp_q.size(), 0);
        // R9 pops on empty ignored
        chk("R9", "level empty", level_o, 0);
        chk("R9", "valid low", px_valid, 0);
        idle(2);
        chk("R2", "overflow sticky", stat_o[2], 1);
        wr(3'd3, 32'h4);
        chk("R5", "clear overflow", stat_o, 3'b001);

        // R7 flush on disable
        wr(3'd0, 32'h1);
        for (int i = 0; i < 3; i++) push_px(32'hC000_0000 + i);
        wr(3'd0, 32'h0);
        flush_model();
        chk("R7", "flush level", level_o, 0);
        chk("R7", "flush valid", px_valid, 0);
        chk("R7", "disabled", cfg_en, 0);

        // R3 programmed threshold
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h1);
        for (int i = 0; i < 5; i++) push_px(32'hD000_0000 + i);
        wr(3'd3, 32'h7);
        chk("R3", "above trigger 2", stat_o[1], 0);
        pop_n(3);
        idle(1);
        chk("R3", "at trigger 2", stat_o[1], 1);
        pop_n(2);
        wr(3'd0, 32'h0);
        flush_model();
        chk("R1", "scoreboard empty", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule